// File: doc/BRIEF.md
# Private Peripheral Window Decoder

This block decodes a 4 KB per-cluster window of private peripheral registers and steers each 32-bit access to one of three kinds of target: a small snoop-control register bank that it holds itself, the per-CPU interrupt interfaces, and eight timer instances. Each of the four CPUs owns two timer instances, a plain timer and a watchdog. The interrupt interface and timer logic sit outside the block. The decoder drives a one-hot select and a register offset to them, and it takes their read data back through a multiplexer.

The interrupt interfaces and the timers each have two kinds of window. An alias window reaches the resources of whichever CPU makes the access, as given by the requester CPU index input. A set of explicit windows, one 256-byte page per CPU, reaches a named CPU's resources from anywhere. Inside a timer page, a single address bit picks the timer or the watchdog. Any access that lands outside the defined ranges, or on an undefined snoop-control register, raises an error pulse in the same cycle and returns zero.

Requests are combinational and the response comes back in the cycle of the access. The only storage is the single writable snoop-control enable bit, which updates on the clock edge that ends a write.

Top module: `ppw_decoder`

## Requirements
- R1: After reset the snoop enable bit is 0, so a read of offset 0x000 returns 0 and `snoop_en` is 0.
- R2: Only address bits 11:0 are decoded, and bits 31:12 have no effect on routing or data.
- R3: Snoop-control reads return these values, with no error: offset 0x000 gives the enable bit in bit 0 and zeros elsewhere, 0x004 gives 0x000000F3, and 0x008 and 0x00C give 0.
- R4: A write to offset 0x000 stores only `req_wdata[0]`. The new value is visible on reads and on `snoop_en` from the next cycle.
- R5: A write to offset 0x00C completes without error and changes no state.
- R6: Offsets 0x100–0x1FF select the interrupt interface of CPU `req_cpu`, with `irq_off` = address bits 7:0. Read data comes from that interface's word in `irq_rdata` (word i at bits 32*i+31:32*i).
- R7: Offsets 0x200–0x5FF select the interrupt interface of CPU (address bits 11:8) − 2, with the same offset and read data rules as R6.
- R8: Offsets 0x600–0x6FF select a timer instance of CPU `req_cpu`. Address bit 5 picks the timer (0) or the watchdog (1), the instance index is cpu*2 + bit 5, `tmr_off` = address bits 3:0, and read data is word `index` of `tmr_rdata`.
- R9: Offsets 0x700–0xAFF select a timer instance of CPU (address bits 11:8) − 7, following the same rules as R8.
- R10: Offsets at or above 0xB00, snoop-control offsets other than 0x000/0x004/0x008/0x00C, and writes to 0x004 or 0x008 raise `rsp_err` in the cycle of the access only. Such an access returns read data 0, asserts no select and changes no state.
- R11: While `req_valid` is low, all selects are 0, `rsp_err` is 0 and `rsp_rdata` is 0.
- R12: At most one bit of `irq_sel` and `tmr_sel` combined is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; bits 11:0 decoded |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Index of the CPU making the access |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_err | output | 1 | Access error pulse |
| irq_sel | output | 4 | One-hot select of an interrupt interface |
| irq_off | output | 8 | Register offset for the interrupt interface |
| irq_rdata | input | 128 | Read words of the four interrupt interfaces |
| tmr_sel | output | 8 | One-hot select of a timer instance |
| tmr_off | output | 4 | Register offset for the timer instance |
| tmr_rdata | input | 256 | Read words of the eight timer instances |
| snoop_en | output | 1 | Current snoop-control enable bit |

## Verification
Most of the decoder is combinational. A wrong range boundary or a wrong page subtraction shows up in the same cycle as the access, as the wrong select bit or as foreign read data. The vectors therefore probe both sides of each window edge and every explicit page. The enable bit is the only state, and a fault in it first shows on the read of offset 0x000, or on `snoop_en`, one cycle after the write. Because of this, every write in the table is followed at once by a read of that register. Writes that must be ignored or rejected are read back in the same way.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

    localparam int MAP_CPUS  = 4;
    localparam int CW        = $clog2(MAP_CPUS);
    localparam int WIN_AW    = 12;

    // window boundaries (exclusive upper ends)
    localparam logic [WIN_AW-1:0] SCU_END       = 12'h100;
    localparam logic [WIN_AW-1:0] IRQ_ALIAS_END = 12'h200;
    localparam logic [WIN_AW-1:0] IRQ_EXPL_END  = 12'h600;
    localparam logic [WIN_AW-1:0] TMR_ALIAS_END = 12'h700;
    localparam logic [WIN_AW-1:0] TMR_EXPL_END  = 12'hB00;

    // first page number of each explicit per-CPU range
    localparam logic [3:0] IRQ_EXPL_PAGE = 4'h2;
    localparam logic [3:0] TMR_EXPL_PAGE = 4'h7;

    // timer/watchdog selector bit inside a timer page
    localparam int TMR_BANK_BIT = 5;

    // snoop-control bank register offsets
    localparam logic [7:0] SNP_CTRL = 8'h00;
    localparam logic [7:0] SNP_CFG  = 8'h04;
    localparam logic [7:0] SNP_STAT = 8'h08;
    localparam logic [7:0] SNP_INV  = 8'h0C;
    localparam logic [31:0] SNP_CFG_WORD = 32'h0000_00F3;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_SNP  = 3'd1,
        RG_IRQ  = 3'd2,
        RG_TMR  = 3'd3,
        RG_ERR  = 3'd4
    } region_e;

    typedef struct packed {
        region_e       region;
        logic [CW-1:0] cpu;
        logic          bank;
        logic [7:0]    off;
    } route_t;

endpackage

// File: rtl/ppw_region_dec.sv
module ppw_region_dec
    import ppw_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              valid,
    input  logic [WIN_AW-1:0] win_addr,
    input  logic [CW-1:0]     cur_cpu,
    output route_t            route
);

    logic [3:0] page;
    logic [3:0] irq_idx;
    logic [3:0] tmr_idx;
    logic       cur_ok;

    assign page    = win_addr[WIN_AW-1:8];
    assign irq_idx = page - IRQ_EXPL_PAGE;
    assign tmr_idx = page - TMR_EXPL_PAGE;
    assign cur_ok  = int'(cur_cpu) < NCPU;

    always_comb begin
        route        = '0;
        route.region = RG_NONE;
        if (valid) begin
            if (win_addr < SCU_END) begin
                route.region = RG_SNP;
                route.off    = win_addr[7:0];
            end else if (win_addr < IRQ_ALIAS_END) begin
                route.region = cur_ok ? RG_IRQ : RG_ERR;
                route.cpu    = cur_cpu;
                route.off    = win_addr[7:0];
            end else if (win_addr < IRQ_EXPL_END) begin
                route.region = (int'(irq_idx) < NCPU) ? RG_IRQ : RG_ERR;
                route.cpu    = irq_idx[CW-1:0];
                route.off    = win_addr[7:0];
            end else if (win_addr < TMR_ALIAS_END) begin
                route.region = cur_ok ? RG_TMR : RG_ERR;
                route.cpu    = cur_cpu;
                route.bank   = win_addr[TMR_BANK_BIT];
                route.off    = {4'h0, win_addr[3:0]};
            end else if (win_addr < TMR_EXPL_END) begin
                route.region = (int'(tmr_idx) < NCPU) ? RG_TMR : RG_ERR;
                route.cpu    = tmr_idx[CW-1:0];
                route.bank   = win_addr[TMR_BANK_BIT];
                route.off    = {4'h0, win_addr[3:0]};
            end else begin
                route.region = RG_ERR;
            end
        end
    end

    // R11: nothing is decoded without a request
    always_comb begin
        p_none_when_idle_r11: assert (valid || route.region == RG_NONE)
            else $error("region decoded without a request");
    end

endmodule

// File: rtl/ppw_snoop_regs.sv
module ppw_snoop_regs
    import ppw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc,
    input  logic        write,
    input  logic [7:0]  off,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        err,
    output logic        en
);

    typedef struct packed {
        logic en;
    } snp_state_t;

    snp_state_t st_d, st_q;
    logic       known;
    logic       ro_write;

    always_comb begin
        known    = (off == SNP_CTRL) || (off == SNP_CFG) ||
                   (off == SNP_STAT) || (off == SNP_INV);
        ro_write = write && ((off == SNP_CFG) || (off == SNP_STAT));
        err      = acc && (!known || ro_write);

        st_d = st_q;
        if (acc && write && off == SNP_CTRL) begin
            st_d.en = wdata[0];
        end

        unique case (off)
            SNP_CTRL: rdata = {31'b0, st_q.en};
            SNP_CFG:  rdata = SNP_CFG_WORD;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en = st_q.en;

    // R4: a control write lands on the next edge with bit 0 only
    p_ctrl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && write && off == SNP_CTRL) |=> (en == $past(wdata[0])));

    // R5 / R10: every other access leaves the enable bit alone
    p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && write && off == SNP_CTRL) |=> $stable(en));

endmodule

// File: rtl/ppw_rdata_mux.sv
module ppw_rdata_mux
    import ppw_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int DW   = 32
) (
    input  route_t                  route,
    input  logic [DW-1:0]           snp_rdata,
    input  logic                    snp_err,
    input  logic [NCPU*DW-1:0]      irq_words,
    input  logic [2*NCPU*DW-1:0]    tmr_words,
    output logic [DW-1:0]           rdata
);

    localparam int NTMR = 2 * NCPU;

    logic [DW-1:0] irq_arr [NCPU];
    logic [DW-1:0] tmr_arr [NTMR];
    logic [CW:0]   tmr_idx;

    for (genvar i = 0; i < NCPU; i++) begin : g_irq_unpack
        assign irq_arr[i] = irq_words[i*DW +: DW];
    end
    for (genvar j = 0; j < NTMR; j++) begin : g_tmr_unpack
        assign tmr_arr[j] = tmr_words[j*DW +: DW];
    end

    assign tmr_idx = {route.cpu, route.bank};

    always_comb begin
        case (route.region)
            RG_SNP:  rdata = snp_err ? '0 : snp_rdata;
            RG_IRQ:  rdata = irq_arr[route.cpu];
            RG_TMR:  rdata = tmr_arr[tmr_idx];
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ppw_decoder.sv
module ppw_decoder
    import ppw_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int DW   = 32,
    parameter int AW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_wdata,
    input  logic [CW-1:0]        req_cpu,
    output logic [DW-1:0]        rsp_rdata,
    output logic                 rsp_err,
    output logic [NCPU-1:0]      irq_sel,
    output logic [7:0]           irq_off,
    input  logic [NCPU*DW-1:0]   irq_rdata,
    output logic [2*NCPU-1:0]    tmr_sel,
    output logic [3:0]           tmr_off,
    input  logic [2*NCPU*DW-1:0] tmr_rdata,
    output logic                 snoop_en
);

    localparam int NTMR = 2 * NCPU;

    route_t        route;
    logic [DW-1:0] snp_rdata;
    logic          snp_err;
    logic          snp_acc;

    ppw_region_dec #(.NCPU(NCPU)) u_dec (
        .valid    (req_valid),
        .win_addr (req_addr[WIN_AW-1:0]),
        .cur_cpu  (req_cpu),
        .route    (route)
    );

    assign snp_acc = (route.region == RG_SNP);

    ppw_snoop_regs u_snp (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (snp_acc),
        .write (req_write),
        .off   (route.off),
        .wdata (req_wdata),
        .rdata (snp_rdata),
        .err   (snp_err),
        .en    (snoop_en)
    );

    ppw_rdata_mux #(.NCPU(NCPU), .DW(DW)) u_mux (
        .route     (route),
        .snp_rdata (snp_rdata),
        .snp_err   (snp_err),
        .irq_words (irq_rdata),
        .tmr_words (tmr_rdata),
        .rdata     (rsp_rdata)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_irq_sel
        assign irq_sel[i] = (route.region == RG_IRQ) && (route.cpu == CW'(i));
    end
    for (genvar j = 0; j < NTMR; j++) begin : g_tmr_sel
        assign tmr_sel[j] = (route.region == RG_TMR) &&
                            ({route.cpu, route.bank} == (CW+1)'(j));
    end

    assign irq_off = route.off;
    assign tmr_off = route.off[3:0];
    assign rsp_err = (route.region == RG_ERR) || snp_err;

    // R12: a single target at most
    p_one_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_sel, tmr_sel}));

    // R10: an error selects nothing and returns zero
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ({irq_sel, tmr_sel} == '0 && rsp_rdata == '0));

    // R11: idle cycles are silent
    p_idle_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rsp_err && {irq_sel, tmr_sel} == '0 && rsp_rdata == '0));

endmodule

// File: tb/ppw_decoder_tb.sv
`timescale 1ns/1ps
module ppw_decoder_tb;

    localparam int NCPU = 4;
    localparam int DW   = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [31:0]          req_addr = '0;
    logic [31:0]          req_wdata = '0;
    logic [1:0]           req_cpu = '0;
    logic [31:0]          rsp_rdata;
    logic                 rsp_err;
    logic [3:0]           irq_sel;
    logic [7:0]           irq_off;
    logic [NCPU*DW-1:0]   irq_rdata;
    logic [7:0]           tmr_sel;
    logic [3:0]           tmr_off;
    logic [2*NCPU*DW-1:0] tmr_rdata;
    logic                 snoop_en;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    for (genvar i = 0; i < NCPU; i++) begin : g_irq_model
        assign irq_rdata[i*DW +: DW] = 32'hA000_0000 | i;
    end
    for (genvar j = 0; j < 2*NCPU; j++) begin : g_tmr_model
        assign tmr_rdata[j*DW +: DW] = 32'hB000_0000 | j;
    end

    ppw_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_cpu   (req_cpu),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .irq_sel   (irq_sel),
        .irq_off   (irq_off),
        .irq_rdata (irq_rdata),
        .tmr_sel   (tmr_sel),
        .tmr_off   (tmr_off),
        .tmr_rdata (tmr_rdata),
        .snoop_en  (snoop_en)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  cpu;
        logic        chk_rd;
        logic [31:0] rd;
        logic [3:0]  isel;
        logic [7:0]  tsel;
        logic [7:0]  off;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 25;
    localparam vec_t VECS [NVEC] = '{
        // R3 snoop reads
        '{1'b0, 32'h0000_0004, 32'h0, 2'd0, 1'b1, 32'h0000_00F3, 4'h0, 8'h00, 8'h00, 1'b0, 8'd3},
        '{1'b0, 32'h0000_0008, 32'h0, 2'd0, 1'b1, 32'h0,         4'h0, 8'h00, 8'h00, 1'b0, 8'd3},
        '{1'b0, 32'h0000_000C, 32'h0, 2'd0, 1'b1, 32'h0,         4'h0, 8'h00, 8'h00, 1'b0, 8'd3},
        // R4 write all ones, then read back 1
        '{1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 2'd0, 1'b0, 32'h0, 4'h0, 8'h00, 8'h00, 1'b0, 8'd4},
        '{1'b0, 32'h0000_0000, 32'h0, 2'd0, 1'b1, 32'h1,         4'h0, 8'h00, 8'h00, 1'b0, 8'd4},
        // R5 invalidate write ignored
        '{1'b1, 32'h0000_000C, 32'h0, 2'd1, 1'b0, 32'h0,         4'h0, 8'h00, 8'h00, 1'b0, 8'd5},
        '{1'b0, 32'h0000_0000, 32'h0, 2'd1, 1'b1, 32'h1,         4'h0, 8'h00, 8'h00, 1'b0, 8'd5},
        // R4 only bit 0 stored
        '{1'b1, 32'h0000_0000, 32'hFFFF_FFFE, 2'd0, 1'b0, 32'h0, 4'h0, 8'h00, 8'h00, 1'b0, 8'd4},
        '{1'b0, 32'h0000_0000, 32'h0, 2'd0, 1'b1, 32'h0,         4'h0, 8'h00, 8'h00, 1'b0, 8'd4},
        // R6 alias interrupt window
        '{1'b0, 32'h0000_0144, 32'h0, 2'd2, 1'b1, 32'hA000_0002, 4'h4, 8'h00, 8'h44, 1'b0, 8'd6},
        '{1'b0, 32'h0000_01FC, 32'h0, 2'd3, 1'b1, 32'hA000_0003, 4'h8, 8'h00, 8'hFC, 1'b0, 8'd6},
        // R7 explicit interrupt pages
        '{1'b0, 32'h0000_0210, 32'h0, 2'd3, 1'b1, 32'hA000_0000, 4'h1, 8'h00, 8'h10, 1'b0, 8'd7},
        '{1'b0, 32'h0000_05F8, 32'h0, 2'd0, 1'b1, 32'hA000_0003, 4'h8, 8'h00, 8'hF8, 1'b0, 8'd7},
        // R8 alias timer window
        '{1'b0, 32'h0000_0600, 32'h0, 2'd1, 1'b1, 32'hB000_0002, 4'h0, 8'h04, 8'h00, 1'b0, 8'd8},
        '{1'b0, 32'h0000_0628, 32'h0, 2'd1, 1'b1, 32'hB000_0003, 4'h0, 8'h08, 8'h08, 1'b0, 8'd8},
        // R9 explicit timer pages
        '{1'b0, 32'h0000_0724, 32'h0, 2'd2, 1'b1, 32'hB000_0001, 4'h0, 8'h02, 8'h04, 1'b0, 8'd9},
        '{1'b0, 32'h0000_0AEC, 32'h0, 2'd0, 1'b1, 32'hB000_0007, 4'h0, 8'h80, 8'h0C, 1'b0, 8'd9},
        '{1'b0, 32'h0000_090C, 32'h0, 2'd0, 1'b1, 32'hB000_0004, 4'h0, 8'h10, 8'h0C, 1'b0, 8'd9},
        // R10 error cases
        '{1'b0, 32'h0000_0B00, 32'h0, 2'd0, 1'b1, 32'h0,         4'h0, 8'h00, 8'h00, 1'b1, 8'd10},
        '{1'b0, 32'h0000_0FFC, 32'h0, 2'd0, 1'b1, 32'h0,         4'h0, 8'h00, 8'h00, 1'b1, 8'd10},
        '{1'b0, 32'h0000_0010, 32'h0, 2'd0, 1'b1, 32'h0,         4'h0, 8'h00, 8'h00, 1'b1, 8'd10},
        '{1'b0, 32'h0000_0002, 32'h0, 2'd0, 1'b1, 32'h0,         4'h0, 8'h00, 8'h00, 1'b1, 8'd10},
        '{1'b1, 32'h0000_0004, 32'h1, 2'd0, 1'b1, 32'h0,         4'h0, 8'h00, 8'h00, 1'b1, 8'd10},
        // R2 upper address bits ignored
        '{1'b0, 32'hFFFF_F004, 32'h0, 2'd0, 1'b1, 32'h0000_00F3, 4'h0, 8'h00, 8'h00, 1'b0, 8'd2},
        '{1'b0, 32'h1234_5A20, 32'h0, 2'd1, 1'b1, 32'hB000_0007, 4'h0, 8'h80, 8'h00, 1'b0, 8'd2}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [31:0] addr,
                         input logic [31:0] wd, input logic [1:0] cpu);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        req_cpu   = cpu;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = 32'h0000_0144;
        #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1 reset state while reset is held
        drive(1'b0, 32'h0, 32'h0, 2'd0);
        check("R1", "rdata in reset", rsp_rdata, 32'h0);
        check("R1", "snoop_en in reset", {31'b0, snoop_en}, 32'h0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        idle();

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[k].req);
            drive(VECS[k].wr, VECS[k].addr, VECS[k].wdata, VECS[k].cpu);
            if (VECS[k].chk_rd) check(tag, "rdata", rsp_rdata, VECS[k].rd);
            check(tag, "err", {31'b0, rsp_err}, {31'b0, VECS[k].err});
            check(tag, "irq_sel", {28'b0, irq_sel}, {28'b0, VECS[k].isel});
            check(tag, "tmr_sel", {24'b0, tmr_sel}, {24'b0, VECS[k].tsel});
            if (VECS[k].isel != 0) check(tag, "irq_off", {24'b0, irq_off}, {24'b0, VECS[k].off});
            if (VECS[k].tsel != 0) check(tag, "tmr_off", {28'b0, tmr_off}, {28'b0, VECS[k].off[3:0]});
        end

        // R10 error is a single-cycle pulse; R11 idle cycle is silent
        drive(1'b0, 32'h0000_0C00, 32'h0, 2'd0);
        check("R10", "err on access", {31'b0, rsp_err}, 32'h1);
        idle();
        check("R10", "err after access", {31'b0, rsp_err}, 32'h0);
        check("R11", "idle irq_sel", {28'b0, irq_sel}, 32'h0);
        check("R11", "idle rdata", rsp_rdata, 32'h0);

        // R4 snoop_en output one cycle after the write; R10 rejected write keeps state
        drive(1'b1, 32'h0000_0000, 32'h1, 2'd0);
        check("R4", "snoop_en before edge", {31'b0, snoop_en}, 32'h0);
        idle();
        check("R4", "snoop_en after edge", {31'b0, snoop_en}, 32'h1);
        drive(1'b1, 32'h0000_0008, 32'h0, 2'd0);
        check("R10", "write to status errors", {31'b0, rsp_err}, 32'h1);
        drive(1'b0, 32'h0000_0000, 32'h0, 2'd0);
        check("R10", "state kept after bad write", rsp_rdata, 32'h1);

        // R1 reset clears the enable bit
        idle();
        rst_n = 1'b0;
        #1;
        check("R1", "snoop_en after reset", {31'b0, snoop_en}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 32'h0000_0000, 32'h0, 2'd0);
        check("R1", "ctrl read after reset", rsp_rdata, 32'h0);
        idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule